// File: doc/BRIEF.md
# Oversampled Burst Phase Picker

This block recovers framed bursts from a line sampled at twice the bit rate. It needs no preamble and no phase-tracking loop. Each clock brings one bit period as a pair of samples. The earlier sample feeds the even path and the later one feeds the odd path, so each path carries one sample per bit. A phase step between bursts can put the data edge on top of one sampling instant. It cannot put it on both, so at least one path always sees clean bits.

Each path runs its own exact-match search for a 16-bit start pattern. The first path to find it wins. The even path wins a tie. The winner stays selected for the whole burst. From the bit that completes the start pattern, the selected path is cut into bytes and forwarded. The burst ends when a 16-bit end pattern appears on a byte boundary. The end pattern is never forwarded. The block then drops the selection and starts a fresh search on both paths. For continuous traffic with no phase steps, a bypass control keeps the even path permanently and ignores the odd one.

Top module: `burst_phase_picker`

## Requirements
- R1: Bit 0 of `samp_pair` feeds the even path and bit 1 the odd path. Each path collects bits first-received-first. When the last 16 bits of a path equal the start pattern, and at least 16 pairs have arrived since reset or since the last burst end, `burst_start` pulses in the cycle after the pair that completed the match.
- R2: If both paths complete the start pattern on the same pair, the even path is selected.
- R3: Once a path is selected, no further `burst_start` occurs and the selection does not change until the burst ends. A start pattern appearing on the other path during the burst has no effect on the output bytes.
- R4: The first payload byte is the 8 bits that directly follow the start pattern. The first-received bit lands in bit 7. The first `rx_valid` comes 16 cycles after `burst_start`, and each later byte comes 8 cycles after the previous one. This one-byte holdback lets the end pattern be withheld.
- R5: At the second and each later byte boundary of a burst, the block checks the last 16 bits of the selected path. If they equal the end pattern, `burst_end` pulses and no byte is emitted for those 16 bits. The block then needs 16 fresh pairs before it can detect a new start.
- R6: With `bypass` high, only the even path is searched. A start pattern present only on the odd path produces no burst.
- R7: Runs of more than 1000 identical bits do not cause a false start, a false end or a lost byte, before a burst or inside its payload. This holds as long as neither pattern is all zeros or all ones.
- R8: A synchronous active-high `rst` clears the outputs, the selection and both searches. A burst that has locked but not ended when `rst` is asserted is abandoned, and the next burst is recovered on either path.
- R9: `rx_valid`, `burst_start` and `burst_end` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One cycle per bit period |
| rst | input | 1 | Synchronous active-high reset |
| samp_pair | input | 2 | Bit 0 earlier (even) sample, bit 1 later (odd) sample |
| delim_cfg | input | 16 | Start pattern, registered inside the block |
| comma_cfg | input | 16 | End pattern, registered inside the block |
| bypass | input | 1 | High: search and forward the even path only |
| rx_byte | output | 8 | Aligned payload byte |
| rx_valid | output | 1 | `rx_byte` holds a new byte |
| burst_start | output | 1 | Start pattern found, path selected |
| burst_end | output | 1 | End pattern found, selection released |

## Verification
The assertions assume three things about the inputs.

- The patterns stay constant during a burst.
- Neither pattern is all zeros or all ones.
- No two adjacent payload bytes spell the end pattern.

Without these, the strobe spacing they check would not hold. The stimulus meets them as follows:

- It fixes both patterns, with a high byte of 8'h7E for the end pattern, before the first burst.
- It replaces any generated payload byte equal to 8'h7E.
- It drives the unreliable path with the inverse of the line. For the chosen start pattern, an inverted idle gap can never form a match.

// File: rtl/burst_phase_picker.sv
module burst_phase_picker #(
  parameter int PAT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        samp_pair,
  input  logic [PAT_W-1:0]  delim_cfg,
  input  logic [PAT_W-1:0]  comma_cfg,
  input  logic              bypass,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              burst_start,
  output logic              burst_end
);
  localparam int FILL_W = $clog2(PAT_W + 1);
  localparam int CNT_W  = $clog2(BYTE_W);

  logic [PAT_W-1:0]  sh_e, sh_o, nx_e, nx_o, win, delim_q, comma_q;
  logic [FILL_W-1:0] fill;
  logic [CNT_W-1:0]  cnt;
  logic              locked, sel, have;
  logic              full, hit_e, hit_o, edge_b, is_comma;

  assign nx_e     = {sh_e[PAT_W-2:0], samp_pair[0]};
  assign nx_o     = {sh_o[PAT_W-2:0], samp_pair[1]};
  assign full     = fill >= FILL_W'(PAT_W - 1);
  assign hit_e    = !locked && full && (nx_e == delim_q);
  assign hit_o    = !locked && full && !bypass && (nx_o == delim_q);
  assign win      = sel ? nx_o : nx_e;
  assign edge_b   = locked && (cnt == CNT_W'(BYTE_W - 1));
  assign is_comma = edge_b && have && (win == comma_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_e        <= '0;
      sh_o        <= '0;
      delim_q     <= '0;
      comma_q     <= '0;
      fill        <= '0;
      cnt         <= '0;
      locked      <= 1'b0;
      sel         <= 1'b0;
      have        <= 1'b0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      burst_start <= 1'b0;
      burst_end   <= 1'b0;
    end else begin
      sh_e        <= nx_e;
      sh_o        <= nx_o;
      delim_q     <= delim_cfg;
      comma_q     <= comma_cfg;
      rx_valid    <= 1'b0;
      burst_start <= 1'b0;
      burst_end   <= 1'b0;
      if (!locked) begin
        if (fill < FILL_W'(PAT_W)) fill <= fill + 1'b1;
        if (hit_e || hit_o) begin
          locked      <= 1'b1;
          sel         <= !hit_e;
          cnt         <= '0;
          have        <= 1'b0;
          burst_start <= 1'b1;
        end
      end else begin
        cnt <= edge_b ? '0 : cnt + 1'b1;
        if (is_comma) begin
          locked    <= 1'b0;
          fill      <= '0;
          burst_end <= 1'b1;
        end else if (edge_b) begin
          have <= 1'b1;
          if (have) begin
            rx_byte  <= win[2*BYTE_W-1:BYTE_W];
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/burst_phase_picker_chk.sv
module burst_phase_picker_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic burst_start,
  input logic burst_end
);
  logic       inb, first;
  logic [7:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      inb   <= 1'b0;
      first <= 1'b0;
      since <= '0;
    end else begin
      if (since != 8'hFF) since <= since + 1'b1;
      if (burst_start) begin
        inb   <= 1'b1;
        first <= 1'b1;
        since <= 8'd1;
      end
      if (rx_valid) begin
        first <= 1'b0;
        since <= 8'd1;
      end
      if (burst_end) inb <= 1'b0;
    end
  end

  p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> !inb);
  p_valid_in_burst_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> inb);
  p_byte_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (since == (first ? 8'd16 : 8'd8)));
  p_end_in_burst_r5: assert property (@(posedge clk) disable iff (rst)
    burst_end |-> inb);
  p_end_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    burst_end |-> (since == (first ? 8'd16 : 8'd8)));
  p_strobes_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid, burst_start, burst_end}));
  p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(rx_valid || burst_start || burst_end));
endmodule

bind burst_phase_picker burst_phase_picker_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid),
  .burst_start(burst_start), .burst_end(burst_end)
);

// File: tb/burst_phase_picker_test.sv
module burst_phase_picker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  samp_pair = 2'b00;
  logic [15:0] delim_cfg = 16'hB5C3;
  logic [15:0] comma_cfg = 16'h7E81;
  logic        bypass = 1'b0;
  logic [7:0]  rx_byte;
  logic        rx_valid, burst_start, burst_end;

  burst_phase_picker uut (
    .clk(clk), .rst(rst), .samp_pair(samp_pair), .delim_cfg(delim_cfg),
    .comma_cfg(comma_cfg), .bypass(bypass), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .burst_start(burst_start), .burst_end(burst_end)
  );

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic gs [0:4095];
  logic bs [0:4095];
  int nbits, nexp, dpos;
  logic [7:0] exp_b [0:255];
  logic [7:0] cap [0:1023];
  int ncap = 0, nstart = 0, nend = 0, novl = 0;
  int s0, e0, c0, v0;
  logic [7:0] lfsr = 8'h5A;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        cap[ncap % 1024] = rx_byte;
        ncap++;
      end
      if (burst_start) nstart++;
      if (burst_end) nend++;
      if ((rx_valid && (burst_start || burst_end)) || (burst_start && burst_end)) novl++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_bit(input logic b);
    gs[nbits] = b;
    nbits++;
  endtask

  task automatic push_word(input logic [15:0] w);
    for (int j = 15; j >= 0; j--) push_bit(w[j]);
  endtask

  task automatic next_byte(output logic [7:0] b);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    b = (lfsr == 8'h7E) ? 8'h3C : lfsr;
  endtask

  // good: 0 clean on even, 1 clean on odd, 2 clean on both
  task automatic burst(input int good, input int gap, input int nb, input bit zeros,
                       input bit bad_delim, input bit inject);
    logic [7:0] b;
    nbits = 0;
    nexp = 0;
    repeat (gap) push_bit(1'b0);
    dpos = nbits;
    push_word(delim_cfg);
    for (int k = 0; k < nb; k++) begin
      if (zeros) b = 8'h00; else next_byte(b);
      exp_b[nexp] = b;
      nexp++;
      for (int j = 7; j >= 0; j--) push_bit(b[j]);
    end
    push_word(comma_cfg);
    repeat (8) push_bit(1'b0);
    for (int i = 0; i < nbits; i++) bs[i] = ~gs[i];
    if (bad_delim) for (int j = 0; j < 16; j++) bs[dpos + j] = delim_cfg[15-j];
    if (inject) for (int j = 0; j < 16; j++) bs[dpos + 24 + j] = delim_cfg[15-j];
    s0 = nstart; e0 = nend; c0 = ncap; v0 = novl;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      samp_pair = (good == 0) ? {bs[i], gs[i]} :
                  (good == 1) ? {gs[i], bs[i]} : {gs[i], gs[i]};
    end
    @(negedge clk);
    samp_pair = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  task automatic verify(input string tag, input bit expect_burst);
    if (expect_burst) begin
      chk(nstart - s0 == 1, {tag, " R1 start count"}, nstart - s0, 1);
      chk(nend - e0 == 1, {tag, " R5 end count"}, nend - e0, 1);
      chk(ncap - c0 == nexp, {tag, " R4 byte count"}, ncap - c0, nexp);
      for (int k = 0; k < nexp && k < ncap - c0; k++)
        chk(cap[(c0 + k) % 1024] == exp_b[k], {tag, " R4 byte value"},
            int'(cap[(c0 + k) % 1024]), int'(exp_b[k]));
    end else begin
      chk(nstart - s0 == 0, {tag, " no start"}, nstart - s0, 0);
      chk(ncap - c0 == 0, {tag, " no bytes"}, ncap - c0, 0);
    end
    chk(novl - v0 == 0, {tag, " R9 strobe overlap"}, novl - v0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rx_valid && !burst_start && !burst_end, "R8 reset outputs",
        int'({rx_valid, burst_start, burst_end}), 0);

    for (int m = 0; m < 3; m++)
      for (int n = 0; n <= 6; n++) begin
        burst(m, 4 + n, n, 1'b0, 1'b0, 1'b0);
        verify($sformatf("R1 sweep path=%0d len=%0d", m, n), 1'b1);
      end

    burst(0, 6, 4, 1'b0, 1'b1, 1'b0);
    verify("R2 tie picks even", 1'b1);

    burst(0, 6, 5, 1'b0, 1'b0, 1'b1);
    verify("R3 frozen even", 1'b1);
    burst(1, 6, 5, 1'b0, 1'b0, 1'b1);
    verify("R3 frozen odd", 1'b1);

    burst(0, 1200, 130, 1'b1, 1'b0, 1'b0);
    verify("R7 long runs even", 1'b1);
    burst(1, 1100, 130, 1'b1, 1'b0, 1'b0);
    verify("R7 long runs odd", 1'b1);

    @(negedge clk);
    bypass = 1'b1;
    burst(1, 8, 3, 1'b1, 1'b0, 1'b0);
    verify("R6 bypass ignores odd", 1'b0);
    burst(0, 8, 3, 1'b0, 1'b0, 1'b0);
    verify("R6 bypass even", 1'b1);
    @(negedge clk);
    bypass = 1'b0;

    for (int j = 15; j >= 0; j--) begin
      @(negedge clk);
      samp_pair = {delim_cfg[j], delim_cfg[j]};
    end
    @(negedge clk);
    samp_pair = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    burst(1, 5, 3, 1'b0, 1'b0, 1'b0);
    verify("R8 reset clears lock", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, miscompares + 1);
    $finish;
  end
endmodule